// File: doc/BRIEF.md
# Per-Packet Traffic-ID and Flow-Override Resolver

This block takes the quality-of-service fields of one accepted transmit descriptor and turns them into the steering controls used downstream: a 3-bit traffic identifier (TID), a TID-overwrite enable, a flow-override enable and its one-bit value, a 2-bit classify-select and a 2-bit drop color. The TID has three possible sources, tried in a fixed order. An explicit override byte is used when its flag is set. Failing that, a force bit inside the same byte is used. Failing that, a programmable priority-to-TID table is used, but only for destinations whose port settings enable it.

The destination word is split into a 4-bit kind nibble (bits [15:12]) and a 12-bit identifier (bits [11:0]). Per-port settings exist only for virtual ports, which are port-ID destinations with identifiers in 64..255. Every other destination reads all-zero settings and raises an unsupported flag. The settings and the 16-entry table are loaded through a one-cycle write strobe. One result comes out, registered, in the cycle after each input strobe.

Top module: `qos_tid_resolver`

## Requirements
- R1: `res_valid` is high in exactly the cycle after a cycle with `pkt_valid` high, and low otherwise. After reset every output is 0.
- R2: With `qos_flag`=1: `tid`=`qos_byte[3:1]`, `cls_sel`=`qos_byte[5:4]`, `flow_val`=`qos_byte[0]`, and `tid_ovr`=1, `flow_en`=1.
- R3: With `qos_flag`=0 and `qos_byte[7]`=1: `tid`=`qos_byte[3:1]`, `tid_ovr`=1, `flow_en`=0, `flow_val`=0, `cls_sel`=0.
- R4: With `qos_flag`=0, `qos_byte[7]`=0 and the destination's use-priority bit (setting bit 0) set: `tid`=table[`int_pri`] and `tid_ovr`=1. If that bit is clear: `tid`=0 and `tid_ovr`=0. In both cases `flow_en`, `flow_val` and `cls_sel` are 0.
- R5: `qos_byte[6]` has no effect on any output.
- R6: A destination is a virtual port only when `dst_info[15:12]`=2 and `dst_info[11:0]` lies in 64..255. For every other kind code (0 invalid, 1 next hop, 3 port bitmap, any other value) and for identifiers 0..63 or above 255, `unsupported`=1 and both setting bits read as 0.
- R7: `color`=`drop_prec` when the destination's drop-enable bit (setting bit 1) is set and `drop_prec` is 0..2. Otherwise `color`=2'b11, the colorless code.
- R8: A setting or table write takes effect from the next cycle. A lookup in the same cycle as a write to the same entry sees the old value.
- R9: With `cfg_tbl`=0, `cfg_addr` is a port identifier and `cfg_data[1:0]` its settings. Writes to identifiers outside 64..255 change nothing. With `cfg_tbl`=1, `cfg_addr[3:0]` selects the table entry and `cfg_data[2:0]` is its TID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | Descriptor fields valid this cycle |
| qos_byte | input | 8 | Override byte |
| qos_flag | input | 1 | Override byte carries a full flow override |
| int_pri | input | 4 | Internal priority, table index |
| drop_prec | input | 2 | Drop precedence |
| dst_info | input | 16 | Destination kind nibble and identifier |
| cfg_we | input | 1 | Write strobe |
| cfg_tbl | input | 1 | 1: table write, 0: port-setting write |
| cfg_addr | input | 12 | Port identifier or table index |
| cfg_data | input | 3 | Setting bits or table TID |
| res_valid | output | 1 | Result valid |
| tid | output | 3 | Resolved traffic identifier |
| tid_ovr | output | 1 | TID overwrite enable |
| flow_en | output | 1 | Flow-override enable |
| flow_val | output | 1 | Flow-override value |
| cls_sel | output | 2 | Classify-select |
| color | output | 2 | Drop color |
| unsupported | output | 1 | Destination is not a virtual port |

## Verification
A lookup and a write to the same port setting or table entry can fall in the same cycle. The bench provokes this by driving a packet to a port or priority in the very cycle that rewrites that entry. The reference model computes the expected result before it applies the write, so the packet must show the old TID and color, and a packet sent straight afterwards must show the new ones. Back-to-back packets with writes in between also test that a result is never taken from a later write.

// File: rtl/qos_tid_resolver.sv
module qos_tid_resolver #(
  parameter int VP_LO = 64,
  parameter int VP_HI = 255,
  parameter int PRI_W = 4,
  parameter int TID_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  input  logic [7:0]       qos_byte,
  input  logic             qos_flag,
  input  logic [PRI_W-1:0] int_pri,
  input  logic [1:0]       drop_prec,
  input  logic [15:0]      dst_info,
  input  logic             cfg_we,
  input  logic             cfg_tbl,
  input  logic [11:0]      cfg_addr,
  input  logic [2:0]       cfg_data,
  output logic             res_valid,
  output logic [TID_W-1:0] tid,
  output logic             tid_ovr,
  output logic             flow_en,
  output logic             flow_val,
  output logic [1:0]       cls_sel,
  output logic [1:0]       color,
  output logic             unsupported
);
  localparam int NVP  = VP_HI - VP_LO + 1;
  localparam int NPRI = 1 << PRI_W;
  localparam int IW   = $clog2(NVP);
  localparam logic [1:0] COLORLESS = 2'b11;

  logic [1:0]       pcfg [NVP];
  logic [TID_W-1:0] ptbl [NPRI];

  logic [11:0]  pid, waddr_off, rid_off;
  logic         vport, wr_port_ok;
  logic [IW-1:0] rslot, wslot;
  logic [1:0]   cfg_rd;

  assign pid        = dst_info[11:0];
  assign vport      = (dst_info[15:12] == 4'd2) && (pid >= 12'(VP_LO)) && (pid <= 12'(VP_HI));
  assign rid_off    = pid - 12'(VP_LO);
  assign waddr_off  = cfg_addr - 12'(VP_LO);
  assign rslot      = rid_off[IW-1:0];
  assign wslot      = waddr_off[IW-1:0];
  assign wr_port_ok = (cfg_addr >= 12'(VP_LO)) && (cfg_addr <= 12'(VP_HI));
  assign cfg_rd     = vport ? pcfg[rslot] : 2'b00;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NVP; i++) pcfg[i] <= '0;
      for (int j = 0; j < NPRI; j++) ptbl[j] <= '0;
    end else if (cfg_we) begin
      if (cfg_tbl) ptbl[cfg_addr[PRI_W-1:0]] <= cfg_data[TID_W-1:0];
      else if (wr_port_ok) pcfg[wslot] <= cfg_data[1:0];
    end
  end

  logic [TID_W-1:0] n_tid;
  logic             n_ovr;
  logic [1:0]       n_color;

  always_comb begin
    if (qos_flag || qos_byte[7]) begin
      n_tid = qos_byte[3:1];
      n_ovr = 1'b1;
    end else if (cfg_rd[0]) begin
      n_tid = ptbl[int_pri];
      n_ovr = 1'b1;
    end else begin
      n_tid = '0;
      n_ovr = 1'b0;
    end
    n_color = (cfg_rd[1] && drop_prec != COLORLESS) ? drop_prec : COLORLESS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid   <= 1'b0;
      tid         <= '0;
      tid_ovr     <= 1'b0;
      flow_en     <= 1'b0;
      flow_val    <= 1'b0;
      cls_sel     <= '0;
      color       <= '0;
      unsupported <= 1'b0;
    end else begin
      res_valid <= pkt_valid;
      if (pkt_valid) begin
        tid         <= n_tid;
        tid_ovr     <= n_ovr;
        flow_en     <= qos_flag;
        flow_val    <= qos_flag & qos_byte[0];
        cls_sel     <= qos_flag ? qos_byte[5:4] : 2'b00;
        color       <= n_color;
        unsupported <= ~vport;
      end
    end
  end

  a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_valid |=> res_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !pkt_valid |=> !res_valid);
  a_r2_flag_path: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && qos_flag) |=> (flow_en && tid_ovr && tid == $past(qos_byte[3:1])));
  a_r3_force_path: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_valid && !qos_flag && qos_byte[7]) |=> (tid_ovr && !flow_en && cls_sel == 2'b00));
  a_r2_flow_implies_ovr: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flow_en) |-> tid_ovr);
  a_r7_unsup_colorless: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && unsupported) |-> color == COLORLESS);
endmodule

// File: tb/qos_tid_resolver_tb.sv
module qos_tid_resolver_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic pkt_valid = 0, qos_flag = 0, cfg_we = 0, cfg_tbl = 0;
  logic [7:0] qos_byte = 0;
  logic [3:0] int_pri = 0;
  logic [1:0] drop_prec = 0;
  logic [15:0] dst_info = 0;
  logic [11:0] cfg_addr = 0;
  logic [2:0] cfg_data = 0;
  logic res_valid, tid_ovr, flow_en, flow_val, unsupported;
  logic [2:0] tid;
  logic [1:0] cls_sel, color;

  always #(CLK_PERIOD/2) clk = ~clk;

  qos_tid_resolver u_dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .qos_byte(qos_byte),
    .qos_flag(qos_flag), .int_pri(int_pri), .drop_prec(drop_prec), .dst_info(dst_info),
    .cfg_we(cfg_we), .cfg_tbl(cfg_tbl), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
    .res_valid(res_valid), .tid(tid), .tid_ovr(tid_ovr), .flow_en(flow_en),
    .flow_val(flow_val), .cls_sel(cls_sel), .color(color), .unsupported(unsupported)
  );

  int n_chk = 0, n_bad = 0;
  logic [1:0] mdl_cfg [256];
  logic [2:0] mdl_tbl [16];
  logic [10:0] exp_q [$];
  string tag_q [$];

  function automatic logic [10:0] model(logic [7:0] q, logic f, logic [3:0] p,
                                        logic [1:0] dp, logic [15:0] d);
    logic vp; logic [1:0] c; logic [2:0] t; logic o, fe, fv; logic [1:0] cs, col;
    vp = (d[15:12] == 4'd2) && (d[11:0] >= 64) && (d[11:0] <= 255);
    c  = vp ? mdl_cfg[d[7:0]] : 2'b00;
    fe = f; fv = f & q[0]; cs = f ? q[5:4] : 2'b00;
    if (f || q[7]) begin t = q[3:1]; o = 1; end
    else if (c[0]) begin t = mdl_tbl[p]; o = 1; end
    else begin t = 0; o = 0; end
    col = (c[1] && dp != 2'b11) ? dp : 2'b11;
    return {~vp, col, cs, fv, fe, o, t};
  endfunction

  task automatic step(input logic v, input logic [7:0] q, input logic f, input logic [3:0] p,
                      input logic [1:0] dp, input logic [15:0] d, input logic we,
                      input logic tb, input logic [11:0] a, input logic [2:0] wd, input string tag);
    if (v) begin exp_q.push_back(model(q, f, p, dp, d)); tag_q.push_back(tag); end
    if (we) begin
      if (tb) mdl_tbl[a[3:0]] = wd;
      else if (a >= 64 && a <= 255) mdl_cfg[a[7:0]] = wd[1:0];
    end
    pkt_valid = v; qos_byte = q; qos_flag = f; int_pri = p; drop_prec = dp; dst_info = d;
    cfg_we = we; cfg_tbl = tb; cfg_addr = a; cfg_data = wd;
    @(negedge clk);
    pkt_valid = 0; cfg_we = 0;
  endtask

  task automatic pkt(input logic [7:0] q, input logic f, input logic [3:0] p,
                     input logic [1:0] dp, input logic [15:0] d, input string tag);
    step(1, q, f, p, dp, d, 0, 0, 0, 0, tag);
  endtask

  task automatic wr(input logic tb, input logic [11:0] a, input logic [2:0] wd);
    step(0, 0, 0, 0, 0, 0, 1, tb, a, wd, "");
  endtask

  always @(negedge clk) begin
    if (rst_n && res_valid) begin
      logic [10:0] got;
      got = {unsupported, color, cls_sel, flow_val, flow_en, tid_ovr, tid};
      n_chk++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R1 unexpected result: actual %h expected none", got);
      end else begin
        logic [10:0] e; string t;
        e = exp_q.pop_front(); t = tag_q.pop_front();
        if (got !== e) begin
          n_bad++;
          $display("FAIL %s result: actual %h expected %h", t, got, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    for (int i = 0; i < 256; i++) mdl_cfg[i] = 0;
    for (int i = 0; i < 16; i++) mdl_tbl[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    n_chk++;
    if ({res_valid, tid, tid_ovr, flow_en, flow_val, cls_sel, color, unsupported} !== 0) begin
      n_bad++; $display("FAIL R1 reset state: actual nonzero expected 0");
    end
    // R2 flag path, R5 bit6 ignored
    pkt(8'h3F, 1, 0, 0, 16'h2064, "R2");
    pkt(8'h15, 1, 0, 0, 16'h0000, "R2");
    pkt(8'hBF, 1, 0, 0, 16'h2064, "R5");
    pkt(8'hFF, 1, 0, 0, 16'h2064, "R5");
    // R3 force bit
    pkt(8'h8E, 0, 0, 0, 16'h2064, "R3");
    pkt(8'hF3, 0, 0, 0, 16'h2080, "R3");
    pkt(8'hC0, 0, 0, 0, 16'h20C8, "R5");
    // R9 table and port programming
    for (int i = 0; i < 16; i++) wr(1, 12'(i), 3'((i * 3 + 1) & 7));
    wr(0, 100, 3'b011); wr(0, 200, 3'b001); wr(0, 64, 3'b010); wr(0, 255, 3'b011);
    // R4 table lookups
    for (int i = 0; i < 16; i++) pkt(8'h40, 0, 4'(i), 0, 16'h2064, "R4");
    pkt(8'h00, 0, 4'd5, 0, 16'h20C8, "R4");
    pkt(8'h00, 0, 4'd5, 0, 16'h2040, "R4");
    pkt(8'h00, 0, 4'd9, 0, 16'h20FF, "R4");
    pkt(8'h00, 0, 4'd9, 0, 16'h2065, "R4");
    // R6 destination decode
    pkt(8'h00, 0, 4'd3, 2, 16'h0064, "R6");
    pkt(8'h00, 0, 4'd3, 2, 16'h1064, "R6");
    pkt(8'h00, 0, 4'd3, 2, 16'h3064, "R6");
    pkt(8'h00, 0, 4'd3, 2, 16'h7064, "R6");
    pkt(8'h00, 0, 4'd3, 2, 16'h203F, "R6");
    pkt(8'h00, 0, 4'd3, 2, 16'h2020, "R6");
    pkt(8'h00, 0, 4'd3, 2, 16'h2000, "R6");
    pkt(8'h00, 0, 4'd3, 2, 16'h2100, "R6");
    pkt(8'h00, 0, 4'd3, 2, 16'h2164, "R6");
    // R7 color
    for (int i = 0; i < 4; i++) begin
      pkt(8'h00, 0, 0, 2'(i), 16'h2064, "R7");
      pkt(8'h00, 0, 0, 2'(i), 16'h20C8, "R7");
      pkt(8'h00, 0, 0, 2'(i), 16'h2040, "R7");
    end
    // R8 same-cycle write and lookup
    step(1, 8'h00, 0, 4'd7, 1, 16'h2096, 1, 0, 150, 3'b011, "R8");
    pkt(8'h00, 0, 4'd7, 1, 16'h2096, "R8");
    step(1, 8'h00, 0, 4'd7, 1, 16'h2096, 1, 1, 7, 3'd6, "R8");
    pkt(8'h00, 0, 4'd7, 1, 16'h2096, "R8");
    // R9 out-of-range port writes change nothing
    wr(0, 10, 3'b000); wr(0, 300, 3'b000); wr(0, 63, 3'b000); wr(0, 12'hFFF, 3'b000);
    pkt(8'h00, 0, 4'd2, 1, 16'h2064, "R9");
    pkt(8'h00, 0, 4'd2, 1, 16'h20FF, "R9");
    pkt(8'h00, 0, 4'd2, 1, 16'h2096, "R9");
    pkt(8'h00, 0, 4'd2, 1, 16'h20C8, "R9");
    // R1 idle gap
    @(negedge clk); @(negedge clk);
    n_chk++;
    if (res_valid !== 1'b0) begin n_bad++; $display("FAIL R1 idle: actual %b expected 0", res_valid); end
    // mixed traffic with interleaved writes
    lf = 16'hACE1;
    for (int k = 0; k < 300; k++) begin
      logic [15:0] d;
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      d = (k % 5 == 0) ? {lf[15:12], 4'h0, lf[7:0]} : {4'h2, 4'h0, lf[11:4]};
      step(lf[0], {lf[9:2]}, lf[3] & lf[1], lf[15:12], lf[6:5], d,
           lf[10], lf[11], {4'h0, lf[13:6]}, lf[2:0], "R4");
    end
    repeat (3) @(negedge clk);
    n_chk++;
    if (exp_q.size() != 0) begin
      n_bad++; $display("FAIL R1 missing results: actual %0d pending expected 0", exp_q.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule